// File: doc/BRIEF.md
# Branch Resolution and Next-PC Unit

This block holds the fetch program counter of a 32-bit RISC core that has no condition flags. Every cycle it presents the current PC and the sequential address PC+4. A conditional branch is decided straight from two register operands. The unit can test whether the two operands are equal. It can also test the sign bit of the first operand, and for two of the branch kinds it combines that sign bit with a zero test of the same operand.

When the branch condition holds, the next PC is PC+4 plus the sign-extended 16-bit offset scaled by four. A jump replaces the low 28 bits of PC+4 with the 26-bit field followed by two zero bits, and a jump wins over any branch presented in the same cycle. The PC register loads a new value only while the enable input is high. The decode stage drives the branch kind, the operands, the offset and the jump field. The fetch stage uses `pc_o` as its address.

Top module: `npc_unit`

## Requirements
- R1: While `rst_ni` is low, `pc_o` is 0x00000000, and it stays 0x00000000 until the first enabled rising edge after `rst_ni` is released.
- R2: `pc_plus4_o` always equals `pc_o + 4` modulo 2^32.
- R3: With `en_i` low, `pc_o` does not change at a rising clock edge, whatever the other inputs are.
- R4: `br_type_i` = 1 (equal) is taken when `rs_val_i == rt_val_i`. `br_type_i` = 2 (not equal) is taken when the two operands differ.
- R5: `br_type_i` = 3 (below zero) is taken when bit 31 of `rs_val_i` is 1. `br_type_i` = 4 (zero or above) is taken when bit 31 of `rs_val_i` is 0.
- R6: `br_type_i` = 5 (zero or below) is taken when bit 31 of `rs_val_i` is 1 or `rs_val_i` is zero. `br_type_i` = 6 (above zero) is taken when bit 31 of `rs_val_i` is 0 and `rs_val_i` is nonzero.
- R7: `br_type_i` = 0 (no branch) and `br_type_i` = 7 (reserved) are never taken. With `jump_i` low and no taken branch, `taken_o` is 0, and an enabled edge loads `pc_o + 4`.
- R8: With `jump_i` low and a taken branch, `taken_o` is 1, and an enabled edge loads `pc_o + 4 + (sign_extend(offset_i) << 2)`.
- R9: With `jump_i` high, an enabled edge loads `{pc_plus4_o[31:28], jfield_i, 2'b00}`.
- R10: A jump takes priority over a branch: with `jump_i` high, the jump target is loaded even when the branch condition holds, and `taken_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | PC update enable |
| jump_i | input | 1 | Unconditional jump request |
| br_type_i | input | 3 | Branch kind: 0 none, 1 eq, 2 ne, 3 ltz, 4 gez, 5 lez, 6 gtz, 7 reserved |
| rs_val_i | input | 32 | First register operand |
| rt_val_i | input | 32 | Second register operand |
| offset_i | input | 16 | Signed branch offset, in words |
| jfield_i | input | 26 | Jump target field, in words |
| pc_o | output | 32 | Current fetch PC |
| pc_plus4_o | output | 32 | Sequential address PC+4 |
| taken_o | output | 1 | Redirect: a jump or a taken branch |

## Verification
All eight branch codes are swept against a set of operand pairs, and each pair is chosen to separate one pair of tests from another:
- zero against one, which separates the below-zero kinds from the at-or-below-zero kinds;
- the most negative value and all-ones, which expose a check on the wrong bit or a magnitude compare used in place of a sign test;
- equal and unequal positive pairs, which separate equality from the sign tests.

Offsets of zero, +1, the largest positive value and the most negative value tell correct sign extension and scaling apart from zero extension or a missing shift. Jumps are issued from a PC whose top nibble is nonzero, so a lost upper nibble shows up. Jumps are also paired with branches whose condition holds, which checks the priority. Interleaved cycles with the enable low show whether the PC holds.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    BR_NONE = 3'd0,
    BR_EQ   = 3'd1,
    BR_NE   = 3'd2,
    BR_LTZ  = 3'd3,
    BR_GEZ  = 3'd4,
    BR_LEZ  = 3'd5,
    BR_GTZ  = 3'd6,
    BR_RSVD = 3'd7
  } br_kind_e;
endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  br_kind_e          kind_i,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  output logic              met_o
);
  logic same, neg, zero;

  assign same = (a_i == b_i);
  assign neg  = a_i[XLEN-1];
  assign zero = (a_i == '0);

  always_comb begin
    unique case (kind_i)
      BR_EQ:   met_o = same;
      BR_NE:   met_o = !same;
      BR_LTZ:  met_o = neg;
      BR_GEZ:  met_o = !neg;
      BR_LEZ:  met_o = neg || zero;
      BR_GTZ:  met_o = !neg && !zero;
      default: met_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int JMP_W = 26
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [JMP_W-1:0] jf_i,
  output logic [XLEN-1:0]  pc4_o,
  output logic [XLEN-1:0]  br_tgt_o,
  output logic [XLEN-1:0]  jmp_tgt_o
);
  localparam int EXT_W = XLEN - OFF_W - 2;
  localparam int HI_W  = XLEN - JMP_W - 2;

  logic [XLEN-1:0] off_scaled;

  assign pc4_o      = pc_i + XLEN'(4);
  assign off_scaled = {{EXT_W{off_i[OFF_W-1]}}, off_i, 2'b00};
  assign br_tgt_o   = pc4_o + off_scaled;
  // region select: upper bits come from the sequential address
  assign jmp_tgt_o  = {pc4_o[XLEN-1 -: HI_W], jf_i, 2'b00};
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          OFF_W    = 16,
  parameter int          JMP_W    = 26,
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              jump_i,
  input  logic [2:0]        br_type_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [XLEN-1:0]   rt_val_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [JMP_W-1:0]  jfield_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   pc_plus4_o,
  output logic              taken_o
);
  logic [XLEN-1:0] pc_q, pc_d, pc4, br_tgt, jmp_tgt;
  logic            cond_met;

  npc_cond_eval #(.XLEN(XLEN)) u_cond (
    .kind_i (br_kind_e'(br_type_i)),
    .a_i    (rs_val_i),
    .b_i    (rt_val_i),
    .met_o  (cond_met)
  );

  npc_target_gen #(.XLEN(XLEN), .OFF_W(OFF_W), .JMP_W(JMP_W)) u_tgt (
    .pc_i      (pc_q),
    .off_i     (offset_i),
    .jf_i      (jfield_i),
    .pc4_o     (pc4),
    .br_tgt_o  (br_tgt),
    .jmp_tgt_o (jmp_tgt)
  );

  // jump wins over branch
  always_comb begin
    if (jump_i)        pc_d = jmp_tgt;
    else if (cond_met) pc_d = br_tgt;
    else               pc_d = pc4;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pc_q <= XLEN'(RESET_PC);
    else if (en_i) pc_q <= pc_d;
  end

  assign pc_o       = pc_q;
  assign pc_plus4_o = pc4;
  assign taken_o    = jump_i || cond_met;

  p_pc4_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_plus4_o == pc_o + XLEN'(4));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> pc_o == $past(pc_o));

  p_seq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !jump_i && (br_type_i == 3'd0 || br_type_i == 3'd7))
      |=> pc_o == $past(pc_o) + XLEN'(4));

  p_jump_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && jump_i) |=> pc_o[JMP_W+1:0] == {$past(jfield_i), 2'b00});

  p_jump_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && jump_i && cond_met) |=> pc_o == $past(jmp_tgt));

  p_taken_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_i |-> taken_o);
endmodule

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        jump_i = 1'b0;
  logic [2:0]  br_type_i = '0;
  logic [31:0] rs_val_i = '0, rt_val_i = '0;
  logic [15:0] offset_i = '0;
  logic [25:0] jfield_i = '0;
  logic [31:0] pc_o, pc_plus4_o;
  logic        taken_o;

  int n_chk = 0, n_bad = 0;
  logic [31:0] model_pc = 32'h0;

  always #2.5 clk_i = ~clk_i;

  npc_unit u_npc_unit (
    .clk_i, .rst_ni, .en_i, .jump_i, .br_type_i, .rs_val_i, .rt_val_i,
    .offset_i, .jfield_i, .pc_o, .pc_plus4_o, .taken_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit exp_cond(input int t, input logic [31:0] a, input logic [31:0] b);
    case (t)
      1: return a == b;
      2: return a != b;
      3: return $signed(a) < 0;
      4: return $signed(a) >= 0;
      5: return $signed(a) <= 0;
      6: return $signed(a) > 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input int t);
    case (t)
      1, 2: return "R4";
      3, 4: return "R5";
      5, 6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic step(input bit en, input bit jmp, input int t, input logic [31:0] a,
                      input logic [31:0] b, input logic [15:0] off, input logic [25:0] jf);
    bit c;
    logic [31:0] p4, nxt;
    string rq;
    @(negedge clk_i);
    en_i = en; jump_i = jmp; br_type_i = 3'(t); rs_val_i = a; rt_val_i = b;
    offset_i = off; jfield_i = jf;
    #1;
    c  = exp_cond(t, a, b);
    p4 = model_pc + 32'd4;
    check("R2", pc_plus4_o, p4);
    if (jmp) check("R10", {31'b0, taken_o}, 32'd1);
    else     check(req_of(t), {31'b0, taken_o}, {31'b0, c});
    if (!en)      begin nxt = model_pc; rq = "R3"; end
    else if (jmp) begin nxt = {p4[31:28], jf, 2'b00}; rq = c ? "R10" : "R9"; end
    else if (c)   begin nxt = p4 + {{14{off[15]}}, off, 2'b00}; rq = "R8"; end
    else          begin nxt = p4; rq = "R7"; end
    @(posedge clk_i);
    #1;
    check(rq, pc_o, nxt);
    model_pc = nxt;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] vals [6];
    logic [15:0] offs [4];
    vals[0] = 32'h0;          vals[1] = 32'h1;          vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h8000_0000;  vals[4] = 32'h7FFF_FFFF;  vals[5] = 32'h0000_0005;
    offs[0] = 16'h0000; offs[1] = 16'h0001; offs[2] = 16'h7FFF; offs[3] = 16'h8000;

    #12;
    check("R1", pc_o, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    #1 check("R1", pc_o, 32'h0);

    // full sweep of kinds and operand pairs
    for (int t = 0; t < 8; t++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          step(1'b1, 1'b0, t, vals[i], vals[j], offs[(i + j + t) % 4], 26'h0);

    // enable low holds PC across all kinds
    for (int t = 0; t < 8; t++)
      step(1'b0, t[0], t, 32'h0, 32'h0, 16'h0040, 26'h3FF_FFFF);

    // jumps into a nonzero region, with and without a competing branch
    step(1'b1, 1'b1, 0, 32'h0, 32'h1, 16'h0, 26'h200_0000);
    step(1'b1, 1'b1, 0, 32'h0, 32'h1, 16'h0, 26'h3FF_FFFF);
    for (int t = 1; t < 7; t++)
      for (int i = 0; i < 6; i++)
        step(1'b1, 1'b1, t, vals[i], vals[i], 16'h1234, 26'(32'h15_5555 + 32'(t * 7 + i)));

    // branch with extreme offsets near a region boundary
    step(1'b1, 1'b1, 0, 32'h0, 32'h0, 16'h0, 26'h3FF_FFFF);
    step(1'b1, 1'b0, 1, 32'h9, 32'h9, 16'h7FFF, 26'h0);
    step(1'b1, 1'b0, 3, 32'h8000_0000, 32'h0, 16'h8000, 26'h0);
    step(1'b1, 1'b0, 6, 32'h1, 32'h0, 16'hFFFF, 26'h0);

    // reset mid-run returns PC to zero
    @(negedge clk_i); rst_ni = 1'b0;
    #1 check("R1", pc_o, 32'h0);
    model_pc = 32'h0;
    @(negedge clk_i); rst_ni = 1'b1;
    step(1'b0, 1'b1, 1, 32'h0, 32'h0, 16'h0, 26'h1);
    check("R1", pc_o, 32'h0);
    step(1'b1, 1'b0, 0, 32'h0, 32'h0, 16'h0, 26'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule